// File: doc/BRIEF.md
# Packet Integrity Monitor

This block sits at the consuming end of an on-chip network link and observes every flit the sink accepts. It does not stall, alter or buffer the stream. It checks four things. First, the packet framing: start and end markers must appear in order, so a lost or repeated word is caught. Second, the word count of each packet must agree with the length its header command implies. Third, the destination field must name this endpoint. Fourth, both an open packet and a pending arbitration request must keep making progress.

Each fault kind sets its own sticky status bit, which stays set until software clears it. A one-cycle pulse marks every cycle in which a new fault was detected. The first fault after a clean state also latches a fault code and the header of the packet involved. After a framing fault the monitor realigns on the next start marker, so the packets that follow are still checked.

Top module: `pkt_integrity_mon`

## Requirements
- R1: A flit is accepted on a cycle where both `flit_valid` and `flit_ready` are high. An accepted flit with `flit_sop` high while a packet is open, or an accepted flit with `flit_sop` low while no packet is open, sets `err_flags[0]` (framing).
- R2: Flits offered while `flit_ready` is low are neither counted nor checked.
- R3: At the accepted flit carrying `flit_eop`, the number of flits counted in the packet (start flit included) is compared with an expected count, and any mismatch sets `err_flags[1]`. The expected count comes from the header fields: opcode is `flit_data[2:0]`, length is `flit_data[6:3]`, destination is `flit_data[10:7]`. Opcodes 1 and 2 expect length+1 flits, opcode 4 expects 2 flits, and every other opcode expects 1 flit.
- R4: An accepted start flit whose destination field differs from parameter `NODE_ID` (default 5) sets `err_flags[2]` (misroute).
- R5: Suppose a packet is open and no flit has been accepted for `tmo_limit` consecutive clock edges. Then `err_flags[3]` is set on the `tmo_limit`-th edge. A value of 0 for `tmo_limit` disables this check.
- R6: Suppose `arb_req` has been high with `arb_gnt` low for `tmo_limit` consecutive edges. Then `err_flags[4]` is set (stuck arbiter). Any grant restarts the count.
- R7: A set flag bit stays set until the matching `err_clear` bit is high at a clock edge. A new fault of that kind on the same edge wins over the clear.
- R8: `err_pulse` is high for exactly the one cycle after each edge on which at least one fault was detected.
- R9: When a fault is detected while all flags are clear, `err_code` latches the code of the fault (1 framing, 2 length, 3 misroute, 4 overdue packet, 5 stuck arbiter; the lowest code wins on a tie). `err_hdr` latches the 11-bit header `{dest,len,opcode}` of the packet involved. Both hold until all flags have been cleared and a new fault occurs.
- R10: After a framing fault, checking resumes with the next start flit, and correct packets that follow raise no further fault.
- R11: After reset, all flags, `err_pulse`, `err_code` and `err_hdr` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| flit_valid | input | 1 | Flit offered on the link |
| flit_ready | input | 1 | Sink takes the flit |
| flit_sop | input | 1 | First flit of a packet (carries the header) |
| flit_eop | input | 1 | Last flit of a packet |
| flit_data | input | 32 | Flit payload; header fields in the low bits of the start flit |
| arb_req | input | 1 | Arbitration request being watched |
| arb_gnt | input | 1 | Grant for that request |
| tmo_limit | input | 16 | Timeout limit in cycles, 0 disables |
| err_clear | input | 5 | Per-bit clear of the sticky flags |
| err_flags | output | 5 | Sticky flags: framing, length, misroute, overdue, stuck arbiter |
| err_pulse | output | 1 | One-cycle marker of newly detected faults |
| err_code | output | 3 | Code of the first fault |
| err_hdr | output | 11 | Header of the packet behind the first fault |

## Verification
The hardest cases to reach from the ports are the ones that depend on timing rather than on content. One is a start marker that arrives while an earlier packet is still open. The other is a flit offered without ready in the middle of a packet. The bench builds these by driving single flits through a task that controls the sop, eop and ready bits separately. The two liveness checks are probed exactly at the boundary: the flag must still be clear one edge before the limit and set at the limit edge. For the arbiter check, grants arriving just short of the limit must keep the flag clear.

// File: rtl/pim_pkg.sv
package pim_pkg;
   localparam int NUM_ERR    = 5;
   localparam int CODE_W     = 3;

   localparam int IDX_FRAME   = 0;
   localparam int IDX_LEN     = 1;
   localparam int IDX_ROUTE   = 2;
   localparam int IDX_OVERDUE = 3;
   localparam int IDX_STUCK   = 4;

   // Header command values
   localparam int OPC_WR_BURST = 1;
   localparam int OPC_RD_DATA  = 2;
   localparam int OPC_MSG      = 4;

   typedef enum logic [CODE_W-1:0] {
      CODE_NONE    = 3'd0,
      CODE_FRAME   = 3'd1,
      CODE_LEN     = 3'd2,
      CODE_ROUTE   = 3'd3,
      CODE_OVERDUE = 3'd4,
      CODE_STUCK   = 3'd5
   } fault_code_e;
endpackage

// File: rtl/pim_timer.sv
module pim_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             restart,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;
   logic             armed;

   assign armed   = (limit != '0);
   assign expired = active & ~restart & armed & (cnt_q == limit - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !active) begin
         cnt_q <= '0;
      end else if (armed && (cnt_q < limit)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/pim_frame_track.sv
module pim_frame_track
   import pim_pkg::*;
#(
   parameter int OP_W    = 3,
   parameter int LEN_W   = 4,
   parameter int ID_W    = 4,
   parameter int NODE_ID = 5,
   localparam int HDR_W  = OP_W + LEN_W + ID_W,
   localparam int CNT_W  = LEN_W + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc,
   input  logic             sop,
   input  logic             eop,
   input  logic [HDR_W-1:0] hdr_in,
   output logic             pkt_open,
   output logic             ev_frame,
   output logic             ev_len,
   output logic             ev_route,
   output logic [HDR_W-1:0] ev_hdr
);
   logic             open_q;
   logic [CNT_W-1:0] cnt_q, exp_q;
   logic [HDR_W-1:0] hdr_q;

   logic [OP_W-1:0]  in_op;
   logic [LEN_W-1:0] in_len;
   logic [ID_W-1:0]  in_dst;
   logic [CNT_W-1:0] in_exp, cnt_inc, cnt_now, exp_now;

   function automatic logic [CNT_W-1:0] exp_len(input logic [OP_W-1:0] op,
                                                input logic [LEN_W-1:0] ln);
      logic [CNT_W-1:0] r;
      if (op == OP_W'(OPC_WR_BURST) || op == OP_W'(OPC_RD_DATA))
         r = CNT_W'(ln) + 1'b1;
      else if (op == OP_W'(OPC_MSG))
         r = CNT_W'(2);
      else
         r = CNT_W'(1);
      return r;
   endfunction

   assign in_op  = hdr_in[OP_W-1:0];
   assign in_len = hdr_in[OP_W +: LEN_W];
   assign in_dst = hdr_in[OP_W+LEN_W +: ID_W];
   assign in_exp = exp_len(in_op, in_len);

   assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;
   assign cnt_now = sop ? CNT_W'(1) : cnt_inc;
   assign exp_now = sop ? in_exp : exp_q;

   assign pkt_open = open_q;
   assign ev_frame = acc & ((sop & open_q) | (~sop & ~open_q));
   assign ev_route = acc & sop & (in_dst != ID_W'(NODE_ID));
   assign ev_len   = acc & eop & (sop | open_q) & (cnt_now != exp_now);
   assign ev_hdr   = (acc & sop) ? hdr_in : hdr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         cnt_q  <= '0;
         exp_q  <= '0;
         hdr_q  <= '0;
      end else if (acc) begin
         if (sop) begin
            open_q <= ~eop;
            cnt_q  <= CNT_W'(1);
            exp_q  <= in_exp;
            hdr_q  <= hdr_in;
         end else if (open_q) begin
            cnt_q <= cnt_inc;
            if (eop) open_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/pim_err_log.sv
module pim_err_log
   import pim_pkg::*;
#(
   parameter int HDR_W       = 11,
   parameter bit CAPTURE_HDR = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_ERR-1:0] ev,
   input  logic [HDR_W-1:0]   ev_hdr,
   input  logic [NUM_ERR-1:0] clr,
   output logic [NUM_ERR-1:0] flags,
   output logic               pulse,
   output logic [CODE_W-1:0]  code,
   output logic [HDR_W-1:0]   hdr
);
   logic [NUM_ERR-1:0] flags_q;
   logic               pulse_q;
   logic [CODE_W-1:0]  code_q, code_nx;
   logic               take;

   always_comb begin
      code_nx = CODE_NONE;
      for (int k = NUM_ERR - 1; k >= 0; k--) begin
         if (ev[k]) code_nx = CODE_W'(k + 1);
      end
   end

   assign take = (|ev) & (flags_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags_q <= '0;
         pulse_q <= 1'b0;
         code_q  <= CODE_NONE;
      end else begin
         flags_q <= (flags_q & ~clr) | ev;
         pulse_q <= |ev;
         if (take) code_q <= code_nx;
      end
   end

   generate
      if (CAPTURE_HDR) begin : g_hdr
         logic [HDR_W-1:0] hdr_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    hdr_q <= '0;
            else if (take) hdr_q <= ev_hdr;
         end
         assign hdr = hdr_q;
      end else begin : g_nohdr
         assign hdr = '0;
      end
   endgenerate

   assign flags = flags_q;
   assign pulse = pulse_q;
   assign code  = code_q;
endmodule

// File: rtl/pkt_integrity_mon.sv
module pkt_integrity_mon
   import pim_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int OP_W         = 3,
   parameter int LEN_W        = 4,
   parameter int ID_W         = 4,
   parameter int NODE_ID      = 5,
   parameter int TMO_W        = 16,
   parameter bit ARB_CHECK_EN = 1'b1,
   parameter bit CAPTURE_HDR  = 1'b1,
   localparam int HDR_W       = OP_W + LEN_W + ID_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flit_valid,
   input  logic               flit_ready,
   input  logic               flit_sop,
   input  logic               flit_eop,
   input  logic [DATA_W-1:0]  flit_data,
   input  logic               arb_req,
   input  logic               arb_gnt,
   input  logic [TMO_W-1:0]   tmo_limit,
   input  logic [NUM_ERR-1:0] err_clear,
   output logic [NUM_ERR-1:0] err_flags,
   output logic               err_pulse,
   output logic [CODE_W-1:0]  err_code,
   output logic [HDR_W-1:0]   err_hdr
);
   if (DATA_W < HDR_W) begin : g_bad_data_w
      $error("flit_data too narrow for the header fields");
   end
   if (NODE_ID < 0 || NODE_ID >= (1 << ID_W)) begin : g_bad_node
      $error("NODE_ID does not fit the destination field");
   end
   if (OP_W < 3) begin : g_bad_op_w
      $error("opcode field must be at least 3 bits");
   end
   if (TMO_W < 2) begin : g_bad_tmo_w
      $error("timeout counter too narrow");
   end

   logic               acc;
   logic               pkt_open;
   logic [NUM_ERR-1:0] ev;
   logic [HDR_W-1:0]   ev_hdr;

   assign acc = flit_valid & flit_ready;

   pim_frame_track #(
      .OP_W    (OP_W),
      .LEN_W   (LEN_W),
      .ID_W    (ID_W),
      .NODE_ID (NODE_ID)
   ) i_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .acc      (acc),
      .sop      (flit_sop),
      .eop      (flit_eop),
      .hdr_in   (flit_data[HDR_W-1:0]),
      .pkt_open (pkt_open),
      .ev_frame (ev[IDX_FRAME]),
      .ev_len   (ev[IDX_LEN]),
      .ev_route (ev[IDX_ROUTE]),
      .ev_hdr   (ev_hdr)
   );

   pim_timer #(.CNT_W(TMO_W)) i_overdue (
      .clk     (clk),
      .rst_n   (rst_n),
      .active  (pkt_open),
      .restart (acc),
      .limit   (tmo_limit),
      .expired (ev[IDX_OVERDUE])
   );

   generate
      if (ARB_CHECK_EN) begin : g_arb
         pim_timer #(.CNT_W(TMO_W)) i_stuck (
            .clk     (clk),
            .rst_n   (rst_n),
            .active  (arb_req & ~arb_gnt),
            .restart (arb_gnt),
            .limit   (tmo_limit),
            .expired (ev[IDX_STUCK])
         );
      end else begin : g_noarb
         assign ev[IDX_STUCK] = 1'b0;
      end
   endgenerate

   pim_err_log #(
      .HDR_W       (HDR_W),
      .CAPTURE_HDR (CAPTURE_HDR)
   ) i_log (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev),
      .ev_hdr (ev_hdr),
      .clr    (err_clear),
      .flags  (err_flags),
      .pulse  (err_pulse),
      .code   (err_code),
      .hdr    (err_hdr)
   );
endmodule

// File: rtl/pim_checker.sv
module pim_checker #(
   parameter int ID_W    = 4,
   parameter int HDR_W   = 11,
   parameter int NODE_ID = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             flit_valid,
   input logic             flit_ready,
   input logic             flit_sop,
   input logic [HDR_W-1:0] hdr_bits,
   input logic             pkt_open,
   input logic [4:0]       err_clear,
   input logic [4:0]       err_flags,
   input logic             err_pulse,
   input logic [2:0]       err_code
);
   logic acc;
   assign acc = flit_valid & flit_ready;

   AST_FRAME_FAULT_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      acc && ((flit_sop && pkt_open) || (!flit_sop && !pkt_open)) |=> err_flags[0]); // R1

   AST_MISROUTE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      acc && flit_sop && (hdr_bits[HDR_W-1 -: ID_W] != ID_W'(NODE_ID)) |=> err_flags[2]); // R4

   AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(err_flags) & ~$past(err_clear) & ~err_flags) == 5'd0)); // R7

   AST_PULSE_HAS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      err_pulse |-> (err_flags != 5'd0)); // R8

   AST_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      (err_flags != 5'd0) |-> (err_code != 3'd0 && err_code <= 3'd5)); // R9
endmodule

bind pkt_integrity_mon pim_checker #(
   .ID_W    (ID_W),
   .HDR_W   (HDR_W),
   .NODE_ID (NODE_ID)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .flit_valid (flit_valid),
   .flit_ready (flit_ready),
   .flit_sop   (flit_sop),
   .hdr_bits   (flit_data[HDR_W-1:0]),
   .pkt_open   (pkt_open),
   .err_clear  (err_clear),
   .err_flags  (err_flags),
   .err_pulse  (err_pulse),
   .err_code   (err_code)
);

// File: tb/test_pkt_integrity_mon.sv
module test_pkt_integrity_mon;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 10;
   // {opcode[2:0], len[3:0], dest[3:0], nflits[4:0], expected flags[4:0]}
   localparam logic [20:0] VEC [NVEC] = '{
      {3'd0, 4'd0,  4'd5, 5'd1,  5'b00000},
      {3'd1, 4'd3,  4'd5, 5'd4,  5'b00000},
      {3'd1, 4'd3,  4'd5, 5'd3,  5'b00010},
      {3'd2, 4'd0,  4'd5, 5'd1,  5'b00000},
      {3'd4, 4'd0,  4'd5, 5'd2,  5'b00000},
      {3'd4, 4'd0,  4'd5, 5'd3,  5'b00010},
      {3'd0, 4'd0,  4'd3, 5'd1,  5'b00100},
      {3'd1, 4'd2,  4'd9, 5'd2,  5'b00110},
      {3'd3, 4'd0,  4'd5, 5'd2,  5'b00010},
      {3'd2, 4'd15, 4'd5, 5'd16, 5'b00000}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        flit_valid = 1'b0, flit_ready = 1'b0, flit_sop = 1'b0, flit_eop = 1'b0;
   logic [31:0] flit_data = '0;
   logic        arb_req = 1'b0, arb_gnt = 1'b0;
   logic [15:0] tmo_limit = 16'd20;
   logic [4:0]  err_clear = '0;
   logic [4:0]  err_flags;
   logic        err_pulse;
   logic [2:0]  err_code;
   logic [10:0] err_hdr;

   int n_checks = 0;
   int n_errors = 0;
   int cycles = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_integrity_mon i_pkt_integrity_mon (
      .clk(clk), .rst_n(rst_n),
      .flit_valid(flit_valid), .flit_ready(flit_ready),
      .flit_sop(flit_sop), .flit_eop(flit_eop), .flit_data(flit_data),
      .arb_req(arb_req), .arb_gnt(arb_gnt), .tmo_limit(tmo_limit),
      .err_clear(err_clear), .err_flags(err_flags), .err_pulse(err_pulse),
      .err_code(err_code), .err_hdr(err_hdr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] hdr(input int op, input int ln, input int dst);
      return {21'd0, 4'(dst), 4'(ln), 3'(op)};
   endfunction

   task automatic flit(input bit s, input bit e, input logic [31:0] d, input bit rdy);
      @(negedge clk);
      flit_valid = 1'b1; flit_ready = rdy; flit_sop = s; flit_eop = e; flit_data = d;
      @(negedge clk);
      flit_valid = 1'b0; flit_ready = 1'b0; flit_sop = 1'b0; flit_eop = 1'b0;
   endtask

   task automatic send_pkt(input int op, input int ln, input int dst, input int n);
      for (int k = 0; k < n; k++)
         flit(k == 0, k == n - 1, (k == 0) ? hdr(op, ln, dst) : 32'hABCD0000 + k, 1'b1);
   endtask

   task automatic clear_all();
      err_clear = 5'h1f;
      @(negedge clk);
      err_clear = 5'h00;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 flags", err_flags, 0);
      chk("R11 pulse", err_pulse, 0);
      chk("R11 code", err_code, 0);
      chk("R11 hdr", err_hdr, 0);

      // Table walk: R3 length and R4 routing
      for (int i = 0; i < NVEC; i++) begin
         send_pkt(VEC[i][20:18], VEC[i][17:14], VEC[i][13:10], VEC[i][9:5]);
         chk($sformatf("R3/R4 vec %0d flags", i), err_flags, VEC[i][4:0]);
         clear_all();
      end

      // R2: flit offered without ready is not counted
      flit(1, 0, hdr(1, 1, 5), 1);
      flit(0, 0, 32'h1, 0);
      flit(0, 1, 32'h2, 1);
      chk("R2 unready flit ignored", err_flags, 0);

      // R1 + R8: stray flit with no open packet
      flit(0, 0, 32'h5, 1);
      chk("R1 stray flit flag", err_flags, 5'b00001);
      chk("R8 pulse high", err_pulse, 1);
      chk("R9 code framing", err_code, 1);
      @(negedge clk);
      chk("R8 pulse single cycle", err_pulse, 0);
      repeat (5) @(negedge clk);
      chk("R7 flag holds", err_flags, 5'b00001);
      clear_all();
      chk("R7 cleared", err_flags, 0);

      // R1 + R10: start marker inside an open packet, then resync
      flit(1, 0, hdr(1, 1, 5), 1);
      flit(1, 1, hdr(0, 0, 5), 1);
      chk("R1 reopen flag", err_flags, 5'b00001);
      send_pkt(1, 2, 5, 3);
      send_pkt(0, 0, 5, 1);
      chk("R10 resync later packets clean", err_flags, 5'b00001);
      clear_all();

      // R7: set wins over clear on the same edge
      @(negedge clk);
      err_clear = 5'h01; flit_valid = 1; flit_ready = 1; flit_sop = 0; flit_eop = 1;
      @(negedge clk);
      err_clear = 0; flit_valid = 0; flit_ready = 0; flit_eop = 0;
      chk("R7 set dominates clear", err_flags, 5'b00001);
      clear_all();

      // R9: first fault captured, second does not overwrite
      send_pkt(0, 0, 7, 1);
      send_pkt(1, 3, 5, 2);
      chk("R9 both flags", err_flags, 5'b00110);
      chk("R9 first code", err_code, 3);
      chk("R9 first hdr", err_hdr, hdr(0, 0, 7));
      err_clear = 5'b00100; @(negedge clk); err_clear = 0;
      send_pkt(0, 0, 3, 1);
      chk("R9 code held while flags remain", err_code, 3);
      clear_all();
      send_pkt(1, 0, 5, 3);
      chk("R9 recapture code", err_code, 2);
      chk("R9 recapture hdr", err_hdr, hdr(1, 0, 5));
      clear_all();

      // R5: overdue packet
      tmo_limit = 16'd8;
      flit(1, 0, hdr(1, 3, 5), 1);
      repeat (7) @(negedge clk);
      chk("R5 no flag before limit", err_flags, 0);
      @(negedge clk);
      chk("R5 overdue flag", err_flags, 5'b01000);
      chk("R9 code overdue", err_code, 4);
      for (int k = 0; k < 3; k++) flit(0, k == 2, 32'h7, 1);
      chk("R5 packet completes", err_flags, 5'b01000);
      clear_all();
      tmo_limit = 16'd0;
      flit(1, 0, hdr(1, 1, 5), 1);
      repeat (40) @(negedge clk);
      chk("R5 zero limit disables", err_flags, 0);
      flit(0, 1, 32'h8, 1);
      chk("R5 disabled packet clean", err_flags, 0);

      // R6: grants restart the stuck-arbiter count
      tmo_limit = 16'd6;
      arb_req = 1;
      for (int k = 0; k < 8; k++) begin
         repeat (4) @(negedge clk);
         arb_gnt = 1; @(negedge clk); arb_gnt = 0;
      end
      chk("R6 grants keep clean", err_flags, 0);
      arb_req = 0;
      @(negedge clk);
      arb_req = 1;
      repeat (5) @(negedge clk);
      chk("R6 no flag before limit", err_flags, 0);
      @(negedge clk);
      chk("R6 stuck flag", err_flags, 5'b10000);
      chk("R9 code stuck", err_code, 5);
      arb_req = 0;
      clear_all();

      finish_run();
   end
endmodule